// File: doc/BRIEF.md
# Reference Clock Source Selector

This block picks one synchronization reference out of a parameterized set of candidate inputs. Each candidate offers a quality code, a configured priority, a source-type code and an interface number. A quality-message receiver outside this block provides a signal-present level and a one-cycle message pulse for each candidate. Parsing those messages and recovering the clock are done elsewhere. A candidate that stays silent for too long is taken out of service. Once it has failed, it comes back only after a programmable wait-to-restore time without faults.

In automatic mode the block ranks the usable candidates on four keys in turn: quality, then priority, then source type, then interface number. It always moves to the best one, so a better source that recovers is taken back. When nothing is usable it falls back to the local oscillator. In manual mode the reference comes from configuration and is never switched. If that reference becomes unusable, the block reports holdover. All time windows are counted in whole ticks of an internal prescaler. All outputs are registered, and a one-cycle pulse marks every change of the selection.

Top module: `ref_clk_selector`

## Requirements
- R1: Quality codes rank 0 (PRC) best, then 1 (SSU-A), 2 (SSU-B) and 3 (equipment clock). When `use_ql_i` is high, the lowest code wins. A candidate with a code from 4 to 7 (do-not-use) is never selected.
- R2: When quality codes are equal, or `use_ql_i` is low, the smallest priority value wins.
- R3: When priorities are also equal, the type code decides, and the lower code wins: 0 is an external timing input, 1 a line-recovered clock and 2 a packet-derived clock.
- R4: When types are also equal, the lowest interface number wins. If every key ties, the lowest candidate index wins.
- R5: In automatic mode, with no usable candidate, the outputs are `local_o`=1, `sel_idx_o`=0 and `sel_ql_o`=3. This is also the state right after reset.
- R6: A candidate becomes unusable when its present flag drops, or when LOSS_TICKS ticks pass without a message pulse. If it was the selected candidate, selection runs again. A candidate that has never qualified becomes usable on its first message.
- R7: A failed candidate becomes usable only after it has been present, with messages arriving, for `wtr_ticks_i` whole ticks.
- R8: With `manual_i` high, `sel_idx_o` follows `man_idx_i` and the block never switches. If that candidate is unusable, `holdover_o`=1 and `sel_ql_o`=3. Otherwise `sel_ql_o` is the candidate's quality code.
- R9: Automatic mode is revertive: a better candidate that becomes usable again is re-selected.
- R10: A tick is raised for one cycle in every TICK_DIV clock cycles, and loss and wait-to-restore windows count these ticks.
- R11: `changed_o` pulses for one cycle, together with the new outputs, whenever `sel_idx_o`, `sel_ql_o`, `local_o` or `holdover_o` changes. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| manual_i | input | 1 | Manual selection mode |
| man_idx_i | input | IDX_W | Candidate fixed in manual mode |
| use_ql_i | input | 1 | Quality code takes part in ranking |
| wtr_ticks_i | input | WTR_W | Wait-to-restore length in ticks |
| present_i | input | N_CAND | Per-candidate signal present |
| msg_i | input | N_CAND | Per-candidate message-received pulse |
| ql_i | input | N_CAND*3 | Quality codes, candidate i at bits [3i+2:3i] |
| prio_i | input | N_CAND*PRIO_W | Priorities, candidate i in slice i |
| type_i | input | N_CAND*2 | Source type codes, candidate i in slice i |
| port_i | input | N_CAND*PORT_W | Interface numbers, candidate i in slice i |
| sel_idx_o | output | IDX_W | Selected candidate |
| local_o | output | 1 | Local oscillator in use |
| holdover_o | output | 1 | Manual reference lost |
| sel_ql_o | output | 3 | Quality of the output reference |
| changed_o | output | 1 | One-cycle selection-change pulse |

## Verification
The assertions assume three things about the inputs. Each message pulse lasts one cycle. `man_idx_i` names an existing candidate. The configuration inputs change only between clock edges and never during reset. The stimulus changes configuration and present flags at the falling edge, issues message pulses one cycle wide about once per tick, and keeps the manual index in range. Checks are made only after the registered selection has settled. Loss and restore windows are sampled well away from the tick on which they expire, so the prescaler phase cannot move a result.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
   localparam int QL_W        = 3;
   localparam int TYPE_W      = 2;
   localparam int QL_LAST_OK  = 3;   // codes above this are do-not-use
   localparam logic [QL_W-1:0] QL_OWN = 3'd3;  // local oscillator / holdover

   typedef enum logic [1:0] {
      H_IDLE = 2'd0,
      H_OK   = 2'd1,
      H_FAIL = 2'd2,
      H_WTR  = 2'd3
   } health_e;
endpackage

// File: rtl/ref_sel_tick.sv
module ref_sel_tick #(
   parameter int TICK_DIV = 250_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = $clog2(TICK_DIV);

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = (cnt_q == CNT_W'(TICK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/ref_sel_health.sv
module ref_sel_health
   import ref_sel_pkg::*;
#(
   parameter int LOSS_TICKS = 5,
   parameter int WTR_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             present_i,
   input  logic             msg_i,
   input  logic [WTR_W-1:0] wtr_ticks_i,
   output logic             healthy_o
);
   localparam int SIL_W = $clog2(LOSS_TICKS + 1);

   health_e          st_q;
   logic [SIL_W-1:0] sil_q;
   logic [WTR_W-1:0] wcnt_q;
   logic             timeout;

   assign timeout   = !msg_i && tick_i && (sil_q == SIL_W'(LOSS_TICKS - 1));
   assign healthy_o = (st_q == H_OK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= H_IDLE;
         sil_q  <= '0;
         wcnt_q <= '0;
      end else if (!present_i) begin
         sil_q <= '0;
         if (st_q != H_IDLE) st_q <= H_FAIL;
      end else begin
         if (msg_i)       sil_q <= '0;
         else if (tick_i) sil_q <= sil_q + 1'b1;
         unique case (st_q)
            H_IDLE: if (msg_i) st_q <= H_OK;
            H_OK:   if (timeout) st_q <= H_FAIL;
            H_FAIL: if (msg_i) begin
               st_q   <= H_WTR;
               wcnt_q <= '0;
            end
            H_WTR: begin
               if (timeout)                    st_q   <= H_FAIL;
               else if (wcnt_q >= wtr_ticks_i) st_q   <= H_OK;
               else if (tick_i)                wcnt_q <= wcnt_q + 1'b1;
            end
            default: st_q <= H_FAIL;
         endcase
      end
   end

   p_fail_needs_wtr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q == H_FAIL) |-> (st_q != H_OK));
endmodule

// File: rtl/ref_sel_pick.sv
module ref_sel_pick
   import ref_sel_pkg::*;
#(
   parameter int N_CAND = 4,
   parameter int PRIO_W = 4,
   parameter int PORT_W = 4,
   parameter int IDX_W  = 2
) (
   input  logic [N_CAND-1:0]        elig_i,
   input  logic                     use_ql_i,
   input  logic [N_CAND*QL_W-1:0]   ql_i,
   input  logic [N_CAND*PRIO_W-1:0] prio_i,
   input  logic [N_CAND*TYPE_W-1:0] type_i,
   input  logic [N_CAND*PORT_W-1:0] port_i,
   output logic                     any_o,
   output logic [IDX_W-1:0]         best_o
);
   always_comb begin
      logic [QL_W-1:0]   b_ql, c_ql;
      logic [PRIO_W-1:0] b_pr, c_pr;
      logic [TYPE_W-1:0] b_ty, c_ty;
      logic [PORT_W-1:0] b_po, c_po;
      logic              win;
      any_o  = 1'b0;
      best_o = '0;
      b_ql = '0; b_pr = '0; b_ty = '0; b_po = '0;
      for (int i = 0; i < N_CAND; i++) begin
         c_ql = ql_i[i*QL_W +: QL_W];
         c_pr = prio_i[i*PRIO_W +: PRIO_W];
         c_ty = type_i[i*TYPE_W +: TYPE_W];
         c_po = port_i[i*PORT_W +: PORT_W];
         if (use_ql_i && (c_ql != b_ql)) win = (c_ql < b_ql);
         else if (c_pr != b_pr)           win = (c_pr < b_pr);
         else if (c_ty != b_ty)           win = (c_ty < b_ty);
         else                             win = (c_po < b_po);
         if (elig_i[i] && (!any_o || win)) begin
            any_o  = 1'b1;
            best_o = IDX_W'(i);
            b_ql = c_ql; b_pr = c_pr; b_ty = c_ty; b_po = c_po;
         end
      end
   end
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
   import ref_sel_pkg::*;
#(
   parameter int N_CAND     = 4,
   parameter int PRIO_W     = 4,
   parameter int PORT_W     = 4,
   parameter int WTR_W      = 8,
   parameter int TICK_DIV   = 250_000_000,
   parameter int LOSS_TICKS = 5,
   localparam int IDX_W     = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     manual_i,
   input  logic [IDX_W-1:0]         man_idx_i,
   input  logic                     use_ql_i,
   input  logic [WTR_W-1:0]         wtr_ticks_i,
   input  logic [N_CAND-1:0]        present_i,
   input  logic [N_CAND-1:0]        msg_i,
   input  logic [N_CAND*QL_W-1:0]   ql_i,
   input  logic [N_CAND*PRIO_W-1:0] prio_i,
   input  logic [N_CAND*TYPE_W-1:0] type_i,
   input  logic [N_CAND*PORT_W-1:0] port_i,
   output logic [IDX_W-1:0]         sel_idx_o,
   output logic                     local_o,
   output logic                     holdover_o,
   output logic [QL_W-1:0]          sel_ql_o,
   output logic                     changed_o
);
   initial begin
      a_ncand_min: assert (N_CAND >= 2);
      a_div_min:   assert (TICK_DIV >= 2);
      a_loss_min:  assert (LOSS_TICKS >= 2);
   end

   logic              tick;
   logic [N_CAND-1:0] healthy, elig;
   logic              any_ok;
   logic [IDX_W-1:0]  best_idx;

   ref_sel_tick #(.TICK_DIV(TICK_DIV)) tick_i (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   for (genvar g = 0; g < N_CAND; g++) begin : g_cand
      ref_sel_health #(.LOSS_TICKS(LOSS_TICKS), .WTR_W(WTR_W)) health_i (
         .clk(clk), .rst_n(rst_n), .tick_i(tick),
         .present_i(present_i[g]), .msg_i(msg_i[g]),
         .wtr_ticks_i(wtr_ticks_i), .healthy_o(healthy[g]));
      assign elig[g] = healthy[g] && present_i[g] &&
                       (ql_i[g*QL_W +: QL_W] <= QL_W'(QL_LAST_OK));
   end

   ref_sel_pick #(.N_CAND(N_CAND), .PRIO_W(PRIO_W), .PORT_W(PORT_W),
                  .IDX_W(IDX_W)) pick_i (
      .elig_i(elig), .use_ql_i(use_ql_i), .ql_i(ql_i), .prio_i(prio_i),
      .type_i(type_i), .port_i(port_i), .any_o(any_ok), .best_o(best_idx));

   logic [IDX_W-1:0] n_idx;
   logic             n_loc, n_hold;
   logic [QL_W-1:0]  n_ql;

   always_comb begin
      logic            m_ok;
      logic [QL_W-1:0] m_ql, b_ql;
      m_ok = 1'b0;
      m_ql = QL_OWN;
      b_ql = QL_OWN;
      for (int i = 0; i < N_CAND; i++) begin
         if (man_idx_i == IDX_W'(i)) begin
            m_ok = elig[i];
            m_ql = ql_i[i*QL_W +: QL_W];
         end
         if (best_idx == IDX_W'(i)) b_ql = ql_i[i*QL_W +: QL_W];
      end
      if (manual_i) begin
         n_idx  = man_idx_i;
         n_loc  = 1'b0;
         n_hold = !m_ok;
         n_ql   = m_ok ? m_ql : QL_OWN;
      end else if (any_ok) begin
         n_idx  = best_idx;
         n_loc  = 1'b0;
         n_hold = 1'b0;
         n_ql   = b_ql;
      end else begin
         n_idx  = '0;
         n_loc  = 1'b1;
         n_hold = 1'b0;
         n_ql   = QL_OWN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_idx_o  <= '0;
         local_o    <= 1'b1;
         holdover_o <= 1'b0;
         sel_ql_o   <= QL_OWN;
         changed_o  <= 1'b0;
      end else begin
         sel_idx_o  <= n_idx;
         local_o    <= n_loc;
         holdover_o <= n_hold;
         sel_ql_o   <= n_ql;
         changed_o  <= (n_idx != sel_idx_o) || (n_loc != local_o) ||
                       (n_hold != holdover_o) || (n_ql != sel_ql_o);
      end
   end

   p_chg_on_diff_r11: assert property (@(posedge clk) disable iff (!rst_n)
      changed_o |-> (sel_idx_o != $past(sel_idx_o) || sel_ql_o != $past(sel_ql_o) ||
                     local_o != $past(local_o) || holdover_o != $past(holdover_o)));
   p_quiet_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !changed_o |-> ($stable(sel_idx_o) && $stable(sel_ql_o) &&
                      $stable(local_o) && $stable(holdover_o)));
   p_local_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
      local_o |-> ($past(elig) == '0) && !holdover_o);
   p_hold_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
      holdover_o |-> $past(manual_i));
   p_usable_ql_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!local_o && !holdover_o) |-> (sel_ql_o <= QL_W'(QL_LAST_OK)));
endmodule

// File: tb/ref_clk_selector_tb_top.sv
module ref_clk_selector_tb_top;
   localparam int N = 4;
   localparam int DIV = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       manual = 1'b0, use_ql = 1'b1;
   logic [1:0] man_idx = '0;
   logic [7:0] wtr = 8'd3;
   logic [N-1:0] present = '1, alive = '1, msg = '0;
   logic [2:0] ql   [N];
   logic [3:0] prio [N];
   logic [1:0] typ  [N];
   logic [3:0] prt  [N];
   logic [N*3-1:0] ql_f;
   logic [N*4-1:0] prio_f, prt_f;
   logic [N*2-1:0] typ_f;

   always_comb
      for (int i = 0; i < N; i++) begin
         ql_f[i*3 +: 3]   = ql[i];
         prio_f[i*4 +: 4] = prio[i];
         typ_f[i*2 +: 2]  = typ[i];
         prt_f[i*4 +: 4]  = prt[i];
      end

   logic [1:0] sel_idx;
   logic       loc, hold, chg;
   logic [2:0] sel_ql;

   ref_clk_selector #(.N_CAND(N), .PRIO_W(4), .PORT_W(4), .WTR_W(8),
                      .TICK_DIV(DIV), .LOSS_TICKS(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .manual_i(manual), .man_idx_i(man_idx),
      .use_ql_i(use_ql), .wtr_ticks_i(wtr), .present_i(present), .msg_i(msg),
      .ql_i(ql_f), .prio_i(prio_f), .type_i(typ_f), .port_i(prt_f),
      .sel_idx_o(sel_idx), .local_o(loc), .holdover_o(hold),
      .sel_ql_o(sel_ql), .changed_o(chg));

   int n_chk = 0, n_bad = 0, n_chg = 0;

   always @(negedge clk) if (rst_n && chg) n_chg++;

   // message source: one pulse per live candidate about once per tick
   initial begin
      @(posedge rst_n);
      forever begin
         repeat (DIV) @(negedge clk);
         msg = alive & present;
         @(negedge clk);
         msg = '0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_sel(input string req, input int idx, input int q);
      check(sel_idx == idx, req, sel_idx, idx);
      check(sel_ql == q, req, sel_ql, q);
      check(!loc && !hold, req, {loc, hold}, 0);
   endtask

   task automatic set_default();
      ql   = '{3'd1, 3'd0, 3'd1, 3'd1};
      prio = '{4'd2, 4'd5, 4'd2, 4'd2};
      typ  = '{2'd1, 2'd0, 2'd0, 2'd0};
      prt  = '{4'd3, 4'd1, 4'd7, 4'd2};
      use_ql = 1'b1;
   endtask

   task automatic t_reset();
      set_default();
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(1);
      check(loc == 1'b1, "R5 reset local", loc, 1);
      check(sel_ql == 3 && sel_idx == 0 && !hold && !chg, "R5 reset state",
            sel_ql, 3);
   endtask

   task automatic t_ranking();
      int c0;
      wait_cyc(40);  // first message qualifies without wait-to-restore
      expect_sel("R1 best quality (R6 first message)", 1, 0);
      c0 = n_chg;
      ql[1] = 3'd7;
      wait_cyc(4);
      expect_sel("R1 do-not-use skipped, R4 port tie", 3, 1);
      check(n_chg == c0 + 1, "R11 one pulse per change", n_chg - c0, 1);
      prio[3] = 4'd3;
      wait_cyc(4);
      expect_sel("R2 smaller priority", 2, 1);
      typ[2] = 2'd2;
      wait_cyc(4);
      expect_sel("R3 line before packet", 0, 1);
      c0 = n_chg;
      wait_cyc(30);
      check(n_chg == c0, "R11 no pulse when steady", n_chg - c0, 0);
      use_ql = 1'b0; ql[1] = 3'd2; prio[1] = 4'd1;
      wait_cyc(4);
      expect_sel("R2 quality ignored when disabled", 1, 2);
      set_default();
      wait_cyc(4);
      expect_sel("R1 default back to best quality", 1, 0);
   endtask

   task automatic t_loss_restore();
      alive[1] = 1'b0;
      wait_cyc(30);
      expect_sel("R6 R10 still held inside loss window", 1, 0);
      wait_cyc(140);
      expect_sel("R6 R10 message loss reselects", 3, 1);
      alive[1] = 1'b1;
      wait_cyc(30);
      expect_sel("R7 held out during wait-to-restore", 3, 1);
      wait_cyc(110);
      expect_sel("R9 revert to recovered best", 1, 0);
   endtask

   task automatic t_local();
      present = '0;
      wait_cyc(3);
      check(loc == 1'b1, "R5 local fallback", loc, 1);
      check(sel_ql == 3 && sel_idx == 0 && !hold, "R5 local outputs", sel_ql, 3);
      present = '1;
      wait_cyc(160);
      expect_sel("R7 R9 all restored", 1, 0);
   endtask

   task automatic t_manual();
      int c0;
      manual = 1'b1; man_idx = 2'd2;
      wait_cyc(3);
      expect_sel("R8 manual choice overrides ranking", 2, 1);
      c0 = n_chg;
      ql[2] = 3'd2;
      wait_cyc(3);
      expect_sel("R11 quality-only change", 2, 2);
      check(n_chg == c0 + 1, "R11 pulse on quality change", n_chg - c0, 1);
      present[2] = 1'b0;
      wait_cyc(3);
      check(hold == 1'b1 && !loc, "R8 holdover on loss", hold, 1);
      check(sel_idx == 2 && sel_ql == 3, "R8 no switch in holdover", sel_idx, 2);
      manual = 1'b0;
      wait_cyc(3);
      expect_sel("R9 auto resumes best", 1, 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      t_reset();
      t_ranking();
      t_loss_restore();
      t_local();
      t_manual();
      finish_run();
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end
endmodule